// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is the switching node of a two-dimensional mesh. It has five ports: local, north, east, south and west. Every port has an input side and an output side, and each output side has a registered output. Packets travel as a run of flits. The first flit of a packet names the destination column and row. The block computes a route only for that first flit. It steers the packet by dimension order: it moves along X until the column matches, then along Y until the row matches, and then ejects the packet to the local port. Each output has its own round-robin arbiter. A granted output stays bound to its input until the last flit of the packet has gone through. The flits of two packets therefore never mix on one link.

Flow control uses credits. No ready signal exists. An upstream sender may drive `in_valid` for a port only while it holds a credit for that port. It starts with `FIFO_DEPTH` credits. It spends one credit for each flit it sends. It gets one credit back for each cycle in which `in_credit` for that port is high. On the output side the block keeps one counter per output. The counter starts at `DN_DEPTH`. The block sends a flit only while that counter is non-zero. The downstream receiver pulses `out_credit` once for each slot it frees. A stalled output holds its flits in the input FIFO, and no flit is lost.

A flit is written into the input FIFO on the clock edge where it is presented. Route computation, allocation and crossbar traversal happen in the next cycle, and they load the output register at the following edge.

Top module: `mesh_xy_router`

## Requirements
- R1: A flit is `FLIT_W` bits wide. Bits [1:0] are the type: bit 0 means first flit, bit 1 means last flit. The code 00 is a middle flit and 11 is a packet of one flit. In a first flit, bits [2 +: COORD_W] hold the destination column and bits [2+COORD_W +: COORD_W] hold the destination row. The block forwards every flit unchanged.
- R2: When the destination column is greater than `MY_X`, the packet leaves on east (port 2). When it is less than `MY_X`, the packet leaves on west (port 4). The row is not examined in either case.
- R3: When the column equals `MY_X`, the block looks at the row. A row greater than `MY_Y` leaves on north (port 1). A row less than `MY_Y` leaves on south (port 3). A row equal to `MY_Y` leaves on local (port 0).
- R4: A flit presented on an idle input at clock edge E appears on its output after edge E+1. The `in_credit` pulse for that input appears after the same edge E+1.
- R5: Once an output accepts a first flit that is not also a last flit, it carries only that packet's later flits, in order, until the last flit has passed.
- R6: Each output grants round-robin among the inputs whose first flit requests it. The search starts at the input after the previous packet's winner, in the index order 0 to 4, and the pointer moves only when a last flit is sent.
- R7: An output sends no flit while its credit count is zero. After reset the count is `DN_DEPTH`. Held flits wait in the input FIFO and go out in order once credits return.
- R8: A single-flit packet (type 11) does not hold its output, so another input's packet can use that output in the very next cycle.
- R9: After reset, all `out_valid` and `in_credit` bits are low.
- R10: Packets from different inputs bound for different outputs go through in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Flit present, one bit per input port |
| in_flit | input | 5*FLIT_W | Input flits, port p in slice [p*FLIT_W +: FLIT_W] |
| in_credit | output | 5 | One-cycle pulse when a slot of that input FIFO is freed |
| out_valid | output | 5 | Registered flit valid, one bit per output port |
| out_flit | output | 5*FLIT_W | Registered output flits, port p in slice [p*FLIT_W +: FLIT_W] |
| out_credit | input | 5 | One-cycle pulse from downstream for each freed slot |

## Verification
Assertions check several properties on every cycle. They check that packet framing on every output stays contiguous and that nothing is interleaved. They check that local ejections carry the node's own coordinates and that north and south traffic already has a matching column. They also check that each arbiter grants at most one input, that the credit counters never wrap and that no input FIFO overflows. Other behaviour shows only in the bench scenarios: the exact output chosen for each coordinate case and the one-cycle latency. The same holds for the rotation of winners between contending inputs and the reuse of an output in the cycle right after a single-flit packet. So too for the stall at exactly `DN_DEPTH` flits and the lossless resume.

// File: rtl/mesh_rtr_pkg.sv
package mesh_rtr_pkg;
  localparam int NPORT    = 5;
  localparam int TYPE_W   = 2;
  localparam int FIRST_B  = 0;
  localparam int LAST_B   = 1;

  localparam int P_LOCAL  = 0;
  localparam int P_NORTH  = 1;
  localparam int P_EAST   = 2;
  localparam int P_SOUTH  = 3;
  localparam int P_WEST   = 4;
endpackage

// File: rtl/mesh_rtr_fifo.sv
module mesh_rtr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |-> rd_en);  // R7
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);  // R7
endmodule

// File: rtl/mesh_rtr_xy_route.sv
module mesh_rtr_xy_route #(
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  output logic [4:0]         port_oh
);
  import mesh_rtr_pkg::*;
  localparam logic [COORD_W-1:0] HX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] HY = COORD_W'(MY_Y);

  always_comb begin
    port_oh = '0;
    if (dest_x > HX)      port_oh[P_EAST]  = 1'b1;
    else if (dest_x < HX) port_oh[P_WEST]  = 1'b1;
    else if (dest_y > HY) port_oh[P_NORTH] = 1'b1;
    else if (dest_y < HY) port_oh[P_SOUTH] = 1'b1;
    else                  port_oh[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/mesh_rtr_rr_arb.sv
module mesh_rtr_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] grant
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] TOP = PW'(N - 1);

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;

  always_comb begin
    logic found;
    int   idx;
    grant = '0;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        win        = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr <= '0;
    else if (advance && |grant)  ptr <= (win == TOP) ? '0 : win + 1'b1;
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R6
  AST_ARB_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);  // R6
endmodule

// File: rtl/mesh_rtr_credit.sv
module mesh_rtr_credit #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] MAXC = CW'(DEPTH);

  logic [CW-1:0] cnt;
  assign avail = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= MAXC;
    else begin
      case ({take, give})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CREDIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt != '0));  // R7
  AST_CREDIT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take) |-> (cnt < MAXC));  // R7
endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router #(
  parameter int FLIT_W     = 16,
  parameter int COORD_W    = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int DN_DEPTH   = 4,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          in_valid,
  input  logic [5*FLIT_W-1:0] in_flit,
  output logic [4:0]          in_credit,
  output logic [4:0]          out_valid,
  output logic [5*FLIT_W-1:0] out_flit,
  input  logic [4:0]          out_credit
);
  import mesh_rtr_pkg::*;
  localparam int NP = NPORT;
  localparam int XLSB = TYPE_W;
  localparam int YLSB = TYPE_W + COORD_W;

  logic [FLIT_W-1:0] front   [NP];
  logic [NP-1:0]     route_oh[NP];
  logic [NP-1:0]     fifo_empty;
  logic [NP-1:0]     fifo_full;
  logic [NP-1:0]     pop;

  logic [NP-1:0]     want    [NP];
  logic [NP-1:0]     grant   [NP];
  logic [NP-1:0]     owner   [NP];
  logic [NP-1:0]     locked;
  logic [NP-1:0]     cred_ok;
  logic [NP-1:0]     send;
  logic [FLIT_W-1:0] xbar    [NP];

  // Input side: buffer write stage and route computation
  for (genvar i = 0; i < NP; i++) begin : g_in
    mesh_rtr_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid[i]),
      .wr_data (in_flit[i*FLIT_W +: FLIT_W]),
      .rd_en   (pop[i]),
      .rd_data (front[i]),
      .empty   (fifo_empty[i]),
      .full    (fifo_full[i])
    );

    mesh_rtr_xy_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dest_x  (front[i][XLSB +: COORD_W]),
      .dest_y  (front[i][YLSB +: COORD_W]),
      .port_oh (route_oh[i])
    );
  end

  // Request matrix: first flits request via route, later flits via lock
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        if (fifo_empty[i])
          want[o][i] = 1'b0;
        else if (front[i][FIRST_B])
          want[o][i] = route_oh[i][o] && !locked[o];
        else
          want[o][i] = locked[o] && owner[o][i];
      end
    end
  end

  // Output side: allocation, crossbar, credit tracking
  for (genvar o = 0; o < NP; o++) begin : g_out
    logic sel_last;
    logic sel_first;

    mesh_rtr_rr_arb #(.N(NP)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (want[o] & {NP{cred_ok[o]}}),
      .advance (sel_last),
      .grant   (grant[o])
    );

    mesh_rtr_credit #(.DEPTH(DN_DEPTH)) u_cred (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (send[o]),
      .give  (out_credit[o]),
      .avail (cred_ok[o])
    );

    always_comb begin
      xbar[o] = '0;
      for (int i = 0; i < NP; i++)
        if (grant[o][i]) xbar[o] = xbar[o] | front[i];
    end

    assign send[o]   = |grant[o];
    assign sel_last  = send[o] && xbar[o][LAST_B];
    assign sel_first = send[o] && xbar[o][FIRST_B];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        locked[o] <= 1'b0;
        owner[o]  <= '0;
      end else if (sel_last) begin
        locked[o] <= 1'b0;
      end else if (sel_first) begin
        locked[o] <= 1'b1;
        owner[o]  <= grant[o];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid[o]                 <= 1'b0;
        out_flit[o*FLIT_W +: FLIT_W] <= '0;
      end else begin
        out_valid[o] <= send[o];
        if (send[o]) out_flit[o*FLIT_W +: FLIT_W] <= xbar[o];
      end
    end

    // Checker state built only from the registered output
    logic pkt_open;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pkt_open <= 1'b0;
      else if (out_valid[o]) pkt_open <= !out_flit[o*FLIT_W + LAST_B];
    end

    AST_PKT_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && pkt_open) |-> !out_flit[o*FLIT_W + FIRST_B]);  // R5
    AST_PKT_STARTS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !pkt_open) |-> out_flit[o*FLIT_W + FIRST_B]);  // R5
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < NP; i++)
      for (int o = 0; o < NP; o++)
        if (grant[o][i]) pop[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_credit <= '0;
    else        in_credit <= pop;
  end

  AST_LOCAL_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_LOCAL] && out_flit[P_LOCAL*FLIT_W + FIRST_B]) |->
    (out_flit[P_LOCAL*FLIT_W + XLSB +: COORD_W] == COORD_W'(MY_X) &&
     out_flit[P_LOCAL*FLIT_W + YLSB +: COORD_W] == COORD_W'(MY_Y)));  // R3
  AST_X_BEFORE_Y_N: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_NORTH] && out_flit[P_NORTH*FLIT_W + FIRST_B]) |->
    (out_flit[P_NORTH*FLIT_W + XLSB +: COORD_W] == COORD_W'(MY_X)));  // R2
  AST_X_BEFORE_Y_S: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_SOUTH] && out_flit[P_SOUTH*FLIT_W + FIRST_B]) |->
    (out_flit[P_SOUTH*FLIT_W + XLSB +: COORD_W] == COORD_W'(MY_X)));  // R2
  AST_CREDIT_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_credit != '0) |-> ($past(fifo_empty) & in_credit) == '0);  // R4
endmodule

// File: tb/mesh_xy_router_bench.sv
module mesh_xy_router_bench;
  localparam int FW = 16;
  localparam int CWD = 3;
  localparam int DEP = 4;
  localparam int DND = 4;
  localparam int NP = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      in_valid = '0;
  logic [5*FW-1:0] in_flit = '0;
  logic [4:0]      in_credit;
  logic [4:0]      out_valid;
  logic [5*FW-1:0] out_flit;
  logic [4:0]      out_credit = '0;

  mesh_xy_router #(.FLIT_W(FW), .COORD_W(CWD), .FIFO_DEPTH(DEP),
                   .DN_DEPTH(DND), .MY_X(2), .MY_Y(2)) u_mesh_xy_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .in_credit(in_credit), .out_valid(out_valid), .out_flit(out_flit),
    .out_credit(out_credit));

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  string sb_req = "R1";
  logic [FW-1:0] exp_q [NP][$];
  int up_cred [NP];
  int owed    [NP];
  int rx_cnt  [NP];
  bit hold    [NP];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] ty, input int x,
                                       input int y, input int pl);
    return {8'(pl), 3'(y), 3'(x), ty};
  endfunction

  task automatic send(input int p, input logic [FW-1:0] f, input int dst);
    @(negedge clk);
    while (up_cred[p] == 0) @(negedge clk);
    in_valid[p] = 1'b1;
    in_flit[p*FW +: FW] = f;
    up_cred[p]--;
    exp_q[dst].push_back(f);
    @(posedge clk);
    #1;
    in_valid[p] = 1'b0;
  endtask

  task automatic send_pkt(input int p, input int x, input int y, input int len,
                          input int tag, input int dst);
    for (int k = 0; k < len; k++) begin
      logic [1:0] ty;
      ty = 2'b00;
      if (k == 0) ty[0] = 1'b1;
      if (k == len - 1) ty[1] = 1'b1;
      send(p, mk(ty, x, y, tag + k), dst);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: scoreboard compare, downstream credit return, upstream credits
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o]) begin
          rx_cnt[o]++;
          owed[o]++;
          if (exp_q[o].size() == 0)
            check(1'b0, sb_req, $sformatf("unexpected flit on port %0d", o),
                  longint'(out_flit[o*FW +: FW]), 0);
          else begin
            logic [FW-1:0] e;
            e = exp_q[o].pop_front();
            check(out_flit[o*FW +: FW] == e, sb_req,
                  $sformatf("flit on port %0d", o),
                  longint'(out_flit[o*FW +: FW]), longint'(e));
          end
        end
        if (!hold[o] && owed[o] > 0) begin
          out_credit[o] = 1'b1;
          owed[o]--;
        end else out_credit[o] = 1'b0;
        if (in_credit[o]) up_cred[o]++;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
      begin
        for (int p = 0; p < NP; p++) begin
          up_cred[p] = DEP; owed[p] = 0; rx_cnt[p] = 0; hold[p] = 0;
        end
        idle(3);
        // R9 reset state
        check(out_valid == 5'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
        check(in_credit == 5'b0, "R9", "in_credit in reset", longint'(in_credit), 0);
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 5'b0, "R9", "out_valid after reset", longint'(out_valid), 0);

        // R2 / R3 routing of single flits (type 11 per R1)
        sb_req = "R2";
        send_pkt(0, 3, 0, 1, 8'h10, 2); idle(3);
        send_pkt(0, 0, 4, 1, 8'h11, 4); idle(3);
        send_pkt(0, 3, 3, 1, 8'h12, 2); idle(3);
        sb_req = "R3";
        send_pkt(0, 2, 3, 1, 8'h13, 1); idle(3);
        send_pkt(0, 2, 1, 1, 8'h14, 3); idle(3);
        send_pkt(1, 2, 2, 1, 8'h15, 0); idle(3);
        check(rx_cnt[2] == 2, "R2", "east count", rx_cnt[2], 2);
        check(rx_cnt[4] == 1, "R2", "west count", rx_cnt[4], 1);
        check(rx_cnt[1] == 1 && rx_cnt[3] == 1 && rx_cnt[0] == 1, "R3",
              "north/south/local counts", rx_cnt[1]*100 + rx_cnt[3]*10 + rx_cnt[0], 111);

        // R4 latency: written at edge E, output after E+1
        sb_req = "R4";
        send_pkt(0, 2, 0, 1, 8'h20, 3);
        @(negedge clk);
        check(out_valid[3] == 1'b0, "R4", "south one edge after input", out_valid[3], 0);
        @(negedge clk);
        check(out_valid[3] == 1'b1, "R4", "south two edges after input", out_valid[3], 1);
        check(in_credit[0] == 1'b1, "R4", "credit back to local input", in_credit[0], 1);
        idle(3);

        // R5 / R6 contention on east: N then S (pointer starts at 1)
        sb_req = "R5";
        fork
          send_pkt(1, 4, 2, 3, 8'h30, 2);
          begin
            #2;
            wait (exp_q[2].size() == 3);
            send_pkt(3, 4, 2, 3, 8'h40, 2);
          end
        join
        idle(10);
        check(exp_q[2].size() == 0, "R5", "east queue drained", exp_q[2].size(), 0);
        // R6: pointer now past south, so west wins over north
        sb_req = "R6";
        fork
          begin
            exp_q[2].push_back(mk(2'b01, 4, 2, 8'h60));
            exp_q[2].push_back(mk(2'b10, 4, 2, 8'h61));
            exp_q[2].push_back(mk(2'b01, 4, 2, 8'h50));
            exp_q[2].push_back(mk(2'b10, 4, 2, 8'h51));
          end
          begin
            @(negedge clk);
            in_valid[1] = 1'b1; in_flit[1*FW +: FW] = mk(2'b01, 4, 2, 8'h50);
            in_valid[4] = 1'b1; in_flit[4*FW +: FW] = mk(2'b01, 4, 2, 8'h60);
            up_cred[1]--; up_cred[4]--;
            @(negedge clk);
            in_flit[1*FW +: FW] = mk(2'b10, 4, 2, 8'h51);
            in_flit[4*FW +: FW] = mk(2'b10, 4, 2, 8'h61);
            up_cred[1]--; up_cred[4]--;
            @(negedge clk);
            in_valid[1] = 1'b0; in_valid[4] = 1'b0;
          end
        join
        idle(10);
        check(exp_q[2].size() == 0, "R6", "round-robin order complete", exp_q[2].size(), 0);

        // R10 two outputs in the same cycle
        sb_req = "R10";
        fork
          send_pkt(0, 3, 2, 1, 8'h70, 2);
          send_pkt(4, 2, 4, 1, 8'h71, 1);
        join
        @(negedge clk);
        @(negedge clk);
        check(out_valid[2] && out_valid[1], "R10", "east and north together",
              longint'(out_valid), 5'b00110);
        idle(3);

        // R8 single-flit packets reuse west on consecutive cycles (east first)
        sb_req = "R8";
        fork
          send_pkt(0, 0, 2, 1, 8'h81, 4);
          begin #1; send_pkt(2, 0, 2, 1, 8'h80, 4); end
        join
        begin
          logic [FW-1:0] a, b;
          a = exp_q[4].pop_front(); b = exp_q[4].pop_front();
          exp_q[4].push_back(b); exp_q[4].push_back(a);
        end
        @(negedge clk);
        @(negedge clk);
        check(out_valid[4] == 1'b1, "R8", "west first packet", out_valid[4], 1);
        @(negedge clk);
        check(out_valid[4] == 1'b1, "R8", "west next cycle", out_valid[4], 1);
        idle(3);

        // R7 credit stall on east: exactly DN_DEPTH flits, then resume
        sb_req = "R7";
        hold[2] = 1;
        rx_cnt[2] = 0;
        fork
          send_pkt(0, 5, 1, 6, 8'h90, 2);
        join_none
        idle(25);
        check(rx_cnt[2] == DND, "R7", "east flits while stalled", rx_cnt[2], DND);
        hold[2] = 0;
        idle(25);
        check(rx_cnt[2] == 6, "R7", "east flits after resume", rx_cnt[2], 6);
        for (int o = 0; o < NP; o++)
          check(exp_q[o].size() == 0, "R1", $sformatf("queue %0d empty", o),
                exp_q[o].size(), 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule